// File: doc/BRIEF.md
# Predicated Instruction Commit Unit

This block is the last stage of a small in-order pipeline. It receives one finished instruction per cycle and decides, at that final point, whether the instruction takes effect. Each instruction names a one-bit guard register. A true guard lets the instruction retire. A false guard turns it into a no-op. Because the decision is made this late, a squashed instruction still took up its slot in every earlier stage. However, it changes no register, changes no guard and raises no fault.

Three kinds of work are handled. An ordinary result is written to its destination register. A move-if-zero writes its source value only when its condition operand is zero at commit, so the branch decision becomes a data dependence. A compare writes a pair of guard registers with opposite senses. Guard 0 always reads true, so an instruction that names it is unguarded. A fault from a retiring instruction comes out as a one-cycle pulse that carries the instruction's tag.

Top module: `predicated_commit_unit`

## Requirements
- R1: During and after reset, wbEn and excPulse are 0, and guard registers 1 to 7 read false. The first instruction guarded by any of them is squashed.
- R2: Guard register 0 always reads true. A compare that names index 0 as a target leaves it true.
- R3: An instruction whose guard is false writes no architectural register and no guard register.
- R4: An instruction whose guard is false never raises excPulse, even when inExc is 1.
- R5: A retiring instruction (guard true, class not 3) with inExc=1 makes excPulse 1 for exactly the following cycle, with excTag equal to its inTag. It writes no register.
- R6: A retiring ordinary result (inOp=0) with inExc=0 drives wbEn=1, wbAddr=inDst and wbData=inData in the cycle after its commit edge.
- R7: A move-if-zero (inOp=1) writes inData to inDst only when inCond is zero. When inCond is non-zero, wbEn stays 0.
- R8: A retiring compare (inOp=2) sets guard inPsetT to inCmp and guard inPsetF to the inverse of inCmp. The new values apply to instructions that commit from the next cycle on. If both indices are equal, the inPsetT value wins.
- R9: The no-op class (inOp=3) writes nothing and raises nothing. A cycle with inValid=0 likewise changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is at commit this cycle |
| inOp | input | 2 | Class: 0 result, 1 move-if-zero, 2 compare, 3 no-op |
| inDst | input | 5 | Destination register index |
| inData | input | 32 | Result or move source value |
| inPred | input | 3 | Guard register index |
| inExc | input | 1 | Functional unit flagged a fault |
| inTag | input | 4 | Instruction tag |
| inCond | input | 32 | Condition operand for move-if-zero |
| inPsetT | input | 3 | Guard index that receives the compare result |
| inPsetF | input | 3 | Guard index that receives the inverted result |
| inCmp | input | 1 | Compare outcome |
| wbEn | output | 1 | Register write enable |
| wbAddr | output | 5 | Register write index |
| wbData | output | 32 | Register write value |
| excPulse | output | 1 | Fault raised |
| excTag | output | 4 | Tag of the faulting instruction |

## Verification
The guard is read combinationally at the commit edge. All outputs sit behind one register, so wbEn, wbAddr, wbData, excPulse and excTag are due exactly one clock after the edge that accepts the instruction. A guard written by a compare affects an instruction that commits one cycle later. The bench drives each instruction at a falling edge and samples the outputs at the next falling edge, after a single rising edge. Vectors that depend on a compare are placed directly after it. A bubble that follows a fault confirms that the pulse lasts one cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    OP_ALU   = 2'd0,
    OP_CMOVZ = 2'd1,
    OP_PSET  = 2'd2,
    OP_NOP   = 2'd3
  } opc_e;

  typedef struct packed {
    logic wrReg;
    logic wrPred;
    logic raiseExc;
  } strobe_t;
endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic    inValid,
  input  opc_e    inOp,
  input  logic    inExc,
  input  logic    predRd,
  input  logic    condZero,
  output strobe_t strb
);
  logic retire;
  logic clean;

  always_comb begin
    retire        = inValid && predRd && (inOp != OP_NOP);
    clean         = retire && !inExc;
    strb.wrReg    = clean && ((inOp == OP_ALU) || ((inOp == OP_CMOVZ) && condZero));
    strb.wrPred   = clean && (inOp == OP_PSET);
    strb.raiseExc = retire && inExc;
  end
endmodule

// File: rtl/pcu_dpath.sv
module pcu_dpath
  import pcu_pkg::*;
#(
  parameter int NUM_PREG = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int PIDX_W   = 3,
  parameter int AIDX_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [AIDX_W-1:0] inDst,
  input  logic [DATA_W-1:0] inData,
  input  logic [PIDX_W-1:0] inPred,
  input  logic [TAG_W-1:0]  inTag,
  input  logic [DATA_W-1:0] inCond,
  input  logic [PIDX_W-1:0] inPsetT,
  input  logic [PIDX_W-1:0] inPsetF,
  input  logic              inCmp,
  output logic              predRd,
  output logic              condZero,
  output logic              wbEn,
  output logic [AIDX_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              excPulse,
  output logic [TAG_W-1:0]  excTag
);
  logic [NUM_PREG-1:0] predQ;
  logic [NUM_PREG-1:0] predNext;

  assign predRd   = predQ[inPred];
  assign condZero = (inCond == '0);

  always_comb begin
    predNext    = predQ;
    predNext[0] = 1'b1;
    for (int i = 1; i < NUM_PREG; i++) begin
      if (inPsetF == PIDX_W'(i)) predNext[i] = !inCmp;
      if (inPsetT == PIDX_W'(i)) predNext[i] = inCmp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predQ <= NUM_PREG'(1);
    end else if (strb.wrPred) begin
      predQ <= predNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbEn     <= 1'b0;
      wbAddr   <= '0;
      wbData   <= '0;
      excPulse <= 1'b0;
      excTag   <= '0;
    end else begin
      wbEn     <= strb.wrReg;
      excPulse <= strb.raiseExc;
      if (strb.wrReg) begin
        wbAddr <= inDst;
        wbData <= inData;
      end
      if (strb.raiseExc) excTag <= inTag;
    end
  end
endmodule

// File: rtl/predicated_commit_unit.sv
module predicated_commit_unit
  import pcu_pkg::*;
#(
  parameter int NUM_PREG = 8,
  parameter int NUM_AREG = 32,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [1:0]                  inOp,
  input  logic [$clog2(NUM_AREG)-1:0] inDst,
  input  logic [DATA_W-1:0]           inData,
  input  logic [$clog2(NUM_PREG)-1:0] inPred,
  input  logic                        inExc,
  input  logic [TAG_W-1:0]            inTag,
  input  logic [DATA_W-1:0]           inCond,
  input  logic [$clog2(NUM_PREG)-1:0] inPsetT,
  input  logic [$clog2(NUM_PREG)-1:0] inPsetF,
  input  logic                        inCmp,
  output logic                        wbEn,
  output logic [$clog2(NUM_AREG)-1:0] wbAddr,
  output logic [DATA_W-1:0]           wbData,
  output logic                        excPulse,
  output logic [TAG_W-1:0]            excTag
);
  localparam int PIDX_W = $clog2(NUM_PREG);
  localparam int AIDX_W = $clog2(NUM_AREG);

  strobe_t strb;
  logic    predRd;
  logic    condZero;

  pcu_ctrl u_ctrl (
    .inValid (inValid),
    .inOp    (opc_e'(inOp)),
    .inExc   (inExc),
    .predRd  (predRd),
    .condZero(condZero),
    .strb    (strb)
  );

  pcu_dpath #(
    .NUM_PREG(NUM_PREG), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .PIDX_W(PIDX_W), .AIDX_W(AIDX_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inDst   (inDst),
    .inData  (inData),
    .inPred  (inPred),
    .inTag   (inTag),
    .inCond  (inCond),
    .inPsetT (inPsetT),
    .inPsetF (inPsetF),
    .inCmp   (inCmp),
    .predRd  (predRd),
    .condZero(condZero),
    .wbEn    (wbEn),
    .wbAddr  (wbAddr),
    .wbData  (wbData),
    .excPulse(excPulse),
    .excTag  (excTag)
  );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int PIDX_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        inOp,
  input logic [PIDX_W-1:0] inPred,
  input logic              inExc,
  input logic [TAG_W-1:0]  inTag,
  input logic [DATA_W-1:0] inCond,
  input logic              predRd,
  input logic              wbEn,
  input logic              excPulse,
  input logic [TAG_W-1:0]  excTag
);
  p_guard0_true_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inPred == '0) |-> predRd);

  p_annul_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !predRd) |=> !wbEn);

  p_annul_no_fault_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !predRd) |=> !excPulse);

  p_fault_tag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && predRd && inExc && inOp != 2'd3) |=> (excPulse && excTag == $past(inTag) && !wbEn));

  p_fault_origin_r5: assert property (@(posedge clk) disable iff (!rstN)
    excPulse |-> $past(inValid && inExc));

  p_cmov_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'd1 && inCond != '0) |=> !wbEn);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid || inOp == 2'd3) |=> (!wbEn && !excPulse));
endmodule

bind predicated_commit_unit pcu_checker #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .PIDX_W(PIDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inPred(inPred),
  .inExc(inExc), .inTag(inTag), .inCond(inCond), .predRd(predRd),
  .wbEn(wbEn), .excPulse(excPulse), .excTag(excTag)
);

// File: tb/predicated_commit_unit_bench.sv
module predicated_commit_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [1:0]  inOp;
  logic [4:0]  inDst;
  logic [31:0] inData;
  logic [2:0]  inPred;
  logic        inExc;
  logic [3:0]  inTag;
  logic [31:0] inCond;
  logic [2:0]  inPsetT;
  logic [2:0]  inPsetF;
  logic        inCmp;
  logic        wbEn;
  logic [4:0]  wbAddr;
  logic [31:0] wbData;
  logic        excPulse;
  logic [3:0]  excTag;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  predicated_commit_unit u_predicated_commit_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inDst(inDst),
    .inData(inData), .inPred(inPred), .inExc(inExc), .inTag(inTag),
    .inCond(inCond), .inPsetT(inPsetT), .inPsetF(inPsetF), .inCmp(inCmp),
    .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData), .excPulse(excPulse),
    .excTag(excTag)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  dst;
    logic [31:0] dat;
    logic [2:0]  prd;
    logic        exc;
    logic [3:0]  tag;
    logic [31:0] cnd;
    logic [2:0]  pT;
    logic [2:0]  pF;
    logic        cmp;
    logic        eWe;
    logic        eExc;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 5'd3, 32'h11, 3'd0, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 via guard 0
    '{2'd0, 5'd4, 32'h22, 3'd2, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 guard 2 false after reset
    '{2'd2, 5'd0, 32'h0,  3'd0, 1'b0, 4'd0, 32'd0, 3'd2, 3'd3, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 p2=1 p3=0
    '{2'd0, 5'd5, 32'h33, 3'd2, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 p2 now true
    '{2'd0, 5'd6, 32'h44, 3'd3, 1'b1, 4'd5, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 squashed fault
    '{2'd0, 5'd6, 32'h45, 3'd2, 1'b1, 4'd9, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 fault raised
    '{2'd1, 5'd7, 32'h55, 3'd0, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd7}, // R7 cond zero
    '{2'd1, 5'd7, 32'h56, 3'd0, 1'b0, 4'd0, 32'd7, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 cond non-zero
    '{2'd1, 5'd8, 32'h57, 3'd3, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 squashed move
    '{2'd2, 5'd0, 32'h0,  3'd3, 1'b0, 4'd0, 32'd0, 3'd4, 3'd5, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 squashed compare
    '{2'd0, 5'd9, 32'h66, 3'd4, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 p4 untouched
    '{2'd2, 5'd0, 32'h0,  3'd2, 1'b0, 4'd0, 32'd0, 3'd2, 3'd3, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 p2=0 p3=1
    '{2'd0, 5'd10,32'h77, 3'd2, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 p2 now false
    '{2'd0, 5'd11,32'h88, 3'd3, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 p3 now true
    '{2'd2, 5'd0, 32'h0,  3'd0, 1'b0, 4'd0, 32'd0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 p0 target
    '{2'd0, 5'd12,32'h99, 3'd0, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd2}, // R2 p0 still true
    '{2'd0, 5'd13,32'haa, 3'd1, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 p1 got inverse
    '{2'd3, 5'd14,32'hbb, 3'd0, 1'b1, 4'd2, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd9}  // R9 no-op class
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    inValid = 1'b0; inOp = 2'd0; inDst = '0; inData = '0; inPred = '0;
    inExc = 1'b0; inTag = '0; inCond = '0; inPsetT = '0; inPsetF = '0; inCmp = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    inValid = 1'b1; inOp = v.op; inDst = v.dst; inData = v.dat; inPred = v.prd;
    inExc = v.exc; inTag = v.tag; inCond = v.cnd; inPsetT = v.pT; inPsetF = v.pF;
    inCmp = v.cmp;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0;
    idle();
    @(negedge clk);
    @(negedge clk);
    check("R1", "wbEn in reset", 32'(wbEn), 32'd0);
    check("R1", "excPulse in reset", 32'(excPulse), 32'd0);
    rstN = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[k].req);
      apply(VECS[k]);
      check(rq, $sformatf("vec %0d wbEn", k), 32'(wbEn), 32'(VECS[k].eWe));
      if (VECS[k].eWe) begin
        check(rq, $sformatf("vec %0d wbAddr", k), 32'(wbAddr), 32'(VECS[k].dst));
        check(rq, $sformatf("vec %0d wbData", k), wbData, VECS[k].dat);
      end
      check(rq, $sformatf("vec %0d excPulse", k), 32'(excPulse), 32'(VECS[k].eExc));
      if (VECS[k].eExc)
        check(rq, $sformatf("vec %0d excTag", k), 32'(excTag), 32'(VECS[k].tag));
    end

    // R5: fault pulse lasts one cycle, R9: bubble changes nothing
    apply('{2'd0, 5'd15, 32'hcc, 3'd0, 1'b1, 4'd12, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd5});
    check("R5", "fault pulse", 32'(excPulse), 32'd1);
    check("R5", "fault tag", 32'(excTag), 32'd12);
    check("R5", "faulting write", 32'(wbEn), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R5", "pulse width", 32'(excPulse), 32'd0);
    check("R9", "bubble wbEn", 32'(wbEn), 32'd0);

    // R8: equal targets, true-sense value wins
    apply('{2'd2, 5'd0, 32'h0, 3'd0, 1'b0, 4'd0, 32'd0, 3'd6, 3'd6, 1'b1, 1'b0, 1'b0, 4'd8});
    apply('{2'd0, 5'd16, 32'hdd, 3'd6, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd8});
    check("R8", "equal targets", 32'(wbEn), 32'd1);

    // R1: reset mid-run clears guard 3, which was true
    doReset();
    check("R1", "wbEn after reset", 32'(wbEn), 32'd0);
    apply('{2'd0, 5'd17, 32'hee, 3'd3, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd1});
    check("R1", "guard 3 cleared", 32'(wbEn), 32'd0);
    apply('{2'd0, 5'd18, 32'hef, 3'd6, 1'b0, 4'd0, 32'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd1});
    check("R1", "guard 6 cleared", 32'(wbEn), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule